// File: doc/BRIEF.md
# NAND Command Front End with Column Pointer

This block is the command-side entry of a small-page NAND memory. It watches an 8-bit bus that a host writes one byte at a time; each write is marked by a one-clock strobe standing for the rising edge of the write enable. A byte written with the command latch qualifier high is an opcode. A byte written with the address latch qualifier high is an address byte. Any other byte is page data, which this block does not keep. From that stream it recognises read, program, erase, copy-back, status, identify and reset sequences. It counts address cycles and reports each finished operation for one clock on its result outputs. The report carries the operation kind, the column where the transfer starts, the row address and the page region that was in force.

A page is 528 bytes in three regions: a first half (columns 0 to 255), a second half (256 to 511) and a spare area (512 to 527). The opcode that opens a read picks the region that the column counts from. The second-half choice holds for one operation only. The spare choice stays until another region opcode or a reset. After each array operation a counter holds a busy flag for a set number of clocks. While it is set, only reset and status are heard.

Top module: `nandfe_cmd_front`

## Requirements
- R1: After reset `busy`, `op_valid` and `cmd_reject` are 0, and the pointer selects the first half (region code 0). A program issued with no region opcode before it reports region 0.
- R2: Opcodes 00h, 01h and 50h select region 0, 1 and 2 and open a read. The read is reported with `op_kind`=1 one clock after the strobe of its 4th address byte. Its row is {byte3, byte2, byte1}.
- R3: The reported column is byte0 in region 0, 256+byte0 in region 1, and 512+(byte0 mod 16) in region 2.
- R4: After a read, program or copy-back that used region 1, the pointer returns to region 0.
- R5: Region 2 stays selected across reads and programs until another region opcode or a reset arrives.
- R6: Program is 80h, 4 address bytes, any data, then 10h, reported with `op_kind`=2. Address bytes beyond the 4th are ignored.
- R7: Erase is 60h, 3 address bytes, then D0h, reported with `op_kind`=3, row {byte2, byte1, byte0} and column 0. A 4th address byte is ignored.
- R8: 8Ah, 4 address bytes, then 10h reports a copy-back with `op_kind`=4. This works only if a read has been reported since the last reset. Otherwise 8Ah pulses `cmd_reject`.
- R9: A 10h or D0h that does not close a complete matching sequence pulses `cmd_reject` and returns the decoder to idle.
- R10: An undefined opcode pulses `cmd_reject` and returns to idle. Address bytes received while idle are ignored.
- R11: Read, program, erase and copy-back raise `busy` for BUSY_CYC clocks. While busy, every opcode other than FFh and 70h, and every address byte, has no effect.
- R12: FFh is accepted at any time. It reports `op_kind`=7, raises `busy` for RST_CYC clocks, returns the pointer to region 0 and forgets any copy-back source.
- R13: 70h reports `op_kind`=5 whether or not the block is busy. 90h reports `op_kind`=6 when the block is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-clock strobe: the bus byte is written this cycle |
| cle | input | 1 | Byte is an opcode |
| ale | input | 1 | Byte is an address byte |
| io_in | input | 8 | Bus byte |
| op_valid | output | 1 | Operation reported this cycle |
| op_kind | output | 3 | 1 read, 2 program, 3 erase, 4 copy-back, 5 status, 6 identify, 7 reset |
| op_col | output | 10 | Effective start column |
| op_row | output | 24 | Row address |
| op_region | output | 2 | Pointer region used: 0 first half, 1 second half, 2 spare |
| cmd_reject | output | 1 | Pulse when an opcode is refused |
| busy | output | 1 | Array busy |

## Verification
A pointer left in the wrong region does not show when the fault happens. It shows on the next read or program, in `op_region` and in a column offset by 256 or 512, one clock after that operation's last strobe. A miscounted address cycle makes a read report too early or too late, or turns a good confirm into a `cmd_reject`. A busy counter of the wrong length shows in the number of clocks `busy` is high. A busy flag that stays silent too little or too much shows as a result pulse where none is due, or a missing one, on the clock after a command strobe.

// File: rtl/nandfe_pkg.sv
package nandfe_pkg;
  localparam int BYTE_W     = 8;
  localparam int HALF_SIZE  = 256;
  localparam int SPARE_BASE = 2 * HALF_SIZE;
  localparam int SPARE_SIZE = 16;
  localparam int PAGE_SIZE  = SPARE_BASE + SPARE_SIZE;
  localparam int COL_W      = $clog2(PAGE_SIZE);

  localparam logic [7:0] OPC_PTR_A   = 8'h00;
  localparam logic [7:0] OPC_PTR_B   = 8'h01;
  localparam logic [7:0] OPC_PTR_C   = 8'h50;
  localparam logic [7:0] OPC_PGM     = 8'h80;
  localparam logic [7:0] OPC_CONFIRM = 8'h10;
  localparam logic [7:0] OPC_ERS     = 8'h60;
  localparam logic [7:0] OPC_ERS_GO  = 8'hD0;
  localparam logic [7:0] OPC_CPY_DST = 8'h8A;
  localparam logic [7:0] OPC_STATUS  = 8'h70;
  localparam logic [7:0] OPC_IDENT   = 8'h90;
  localparam logic [7:0] OPC_RESET   = 8'hFF;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_READ = 3'd1, OP_PROG = 3'd2, OP_ERASE = 3'd3,
    OP_COPY = 3'd4, OP_STATUS = 3'd5, OP_IDENT = 3'd6, OP_RESET = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    RG_FIRST = 2'd0, RG_SECOND = 2'd1, RG_SPARE = 2'd2
  } region_e;

  typedef enum logic [2:0] {
    FS_IDLE, FS_RADDR, FS_PADDR, FS_EADDR, FS_CADDR
  } fs_e;

  // Start column for a region and the first address byte.
  function automatic logic [COL_W-1:0] region_col(input region_e rg,
                                                  input logic [BYTE_W-1:0] b);
    case (rg)
      RG_SECOND: return COL_W'(HALF_SIZE) + COL_W'(b);
      RG_SPARE:  return COL_W'(SPARE_BASE) + COL_W'(b & BYTE_W'(SPARE_SIZE - 1));
      default:   return COL_W'(b);
    endcase
  endfunction

  function automatic logic opcode_known(input logic [7:0] c);
    return c inside {OPC_PTR_A, OPC_PTR_B, OPC_PTR_C, OPC_PGM, OPC_CONFIRM,
                     OPC_ERS, OPC_ERS_GO, OPC_CPY_DST, OPC_STATUS, OPC_IDENT,
                     OPC_RESET};
  endfunction
endpackage

// File: rtl/nandfe_addr.sv
module nandfe_addr #(
  parameter int MAX_CYC = 4,
  parameter int BYTE_W  = 8,
  localparam int CNT_W  = $clog2(MAX_CYC + 1),
  localparam int VEC_W  = MAX_CYC * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic [CNT_W-1:0]  limit,
  input  logic [BYTE_W-1:0] din,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [VEC_W-1:0]  bytes_q_o,
  output logic [VEC_W-1:0]  bytes_nx_o,
  output logic              last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             room;
  logic             wr;

  assign room   = cnt_q < limit;
  assign wr     = take && room;
  assign last_o = wr && (cnt_q == limit - CNT_W'(1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (wr)     cnt_q <= cnt_q + CNT_W'(1);
  end

  for (genvar i = 0; i < MAX_CYC; i++) begin : g_slot
    logic [BYTE_W-1:0] slot_q;
    logic              hit;
    assign hit = wr && (cnt_q == CNT_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)   slot_q <= '0;
      else if (hit) slot_q <= din;
    end
    assign bytes_q_o[i*BYTE_W +: BYTE_W]  = slot_q;
    assign bytes_nx_o[i*BYTE_W +: BYTE_W] = hit ? din : slot_q;
  end
endmodule

// File: rtl/nandfe_ptr.sv
module nandfe_ptr
  import nandfe_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    home,
  input  logic    set_en,
  input  region_e set_rg,
  input  logic    use_en,
  output region_e region_o
);
  region_e rg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                           rg_q <= RG_FIRST;
    else if (home)                        rg_q <= RG_FIRST;
    else if (set_en)                      rg_q <= set_rg;
    else if (use_en && rg_q == RG_SECOND) rg_q <= RG_FIRST;
  end

  assign region_o = rg_q;
endmodule

// File: rtl/nandfe_busy.sv
module nandfe_busy #(
  parameter int LONG_CYC = 20,
  parameter int RST_CYC  = 12,
  localparam int PEAK    = (LONG_CYC > RST_CYC) ? LONG_CYC : RST_CYC,
  localparam int CW      = $clog2(PEAK + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_long,
  input  logic load_rst,
  output logic busy_o
);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              left_q <= '0;
    else if (load_rst)       left_q <= CW'(RST_CYC);
    else if (load_long)      left_q <= CW'(LONG_CYC);
    else if (left_q != '0)   left_q <= left_q - CW'(1);
  end

  assign busy_o = (left_q != '0);
endmodule

// File: rtl/nandfe_cmd_front.sv
module nandfe_cmd_front
  import nandfe_pkg::*;
#(
  parameter int RD_CYC   = 4,
  parameter int ER_CYC   = 3,
  parameter int BUSY_CYC = 20,
  parameter int RST_CYC  = 12,
  localparam int ROW_W   = BYTE_W * (RD_CYC - 1),
  localparam int ADDR_W  = BYTE_W * RD_CYC,
  localparam int CNT_W   = $clog2(RD_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              cle,
  input  logic              ale,
  input  logic [BYTE_W-1:0] io_in,
  output logic              op_valid,
  output logic [2:0]        op_kind,
  output logic [COL_W-1:0]  op_col,
  output logic [ROW_W-1:0]  op_row,
  output logic [1:0]        op_region,
  output logic              cmd_reject,
  output logic              busy
);
  fs_e   state_q, state_d;
  logic  src_q;
  op_e   op_kind_q;

  logic cmd_stb, adr_stb, collecting, addr_take, addr_last, addr_clear;
  logic [CNT_W-1:0]  addr_cnt, addr_limit;
  logic [ADDR_W-1:0] addr_q, addr_nx;

  region_e ptr_q, ptr_set_rg, iss_rg;
  logic    ptr_set, ptr_home, ptr_use;
  logic    ld_long, ld_rst, src_set, src_clr;

  // events brought out for the checker
  logic             evt_issue, evt_reject;
  op_e              iss_kind;
  logic [COL_W-1:0] iss_col;
  logic [ROW_W-1:0] iss_row;

  assign cmd_stb    = wr_stb && cle && !ale;
  assign adr_stb    = wr_stb && ale && !cle;
  assign collecting = (state_q != FS_IDLE);
  assign addr_take  = adr_stb && !busy && collecting;
  assign addr_limit = (state_q == FS_EADDR) ? CNT_W'(ER_CYC) : CNT_W'(RD_CYC);

  nandfe_addr #(.MAX_CYC(RD_CYC), .BYTE_W(BYTE_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .clear(addr_clear), .take(addr_take),
    .limit(addr_limit), .din(io_in), .cnt_o(addr_cnt),
    .bytes_q_o(addr_q), .bytes_nx_o(addr_nx), .last_o(addr_last)
  );

  nandfe_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .home(ptr_home), .set_en(ptr_set),
    .set_rg(ptr_set_rg), .use_en(ptr_use), .region_o(ptr_q)
  );

  nandfe_busy #(.LONG_CYC(BUSY_CYC), .RST_CYC(RST_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .load_long(ld_long), .load_rst(ld_rst),
    .busy_o(busy)
  );

  always_comb begin
    state_d    = state_q;
    addr_clear = 1'b0;
    ptr_set    = 1'b0;
    ptr_set_rg = RG_FIRST;
    ptr_home   = 1'b0;
    ptr_use    = 1'b0;
    ld_long    = 1'b0;
    ld_rst     = 1'b0;
    src_set    = 1'b0;
    src_clr    = 1'b0;
    evt_issue  = 1'b0;
    evt_reject = 1'b0;
    iss_kind   = OP_NONE;
    iss_col    = '0;
    iss_row    = '0;
    iss_rg     = ptr_q;
    if (cmd_stb) begin
      if (io_in == OPC_RESET) begin
        evt_issue  = 1'b1;
        iss_kind   = OP_RESET;
        iss_rg     = RG_FIRST;
        ld_rst     = 1'b1;
        ptr_home   = 1'b1;
        src_clr    = 1'b1;
        addr_clear = 1'b1;
        state_d    = FS_IDLE;
      end else if (io_in == OPC_STATUS) begin
        evt_issue = 1'b1;
        iss_kind  = OP_STATUS;
      end else if (!busy) begin
        case (io_in)
          OPC_PTR_A, OPC_PTR_B, OPC_PTR_C: begin
            ptr_set    = 1'b1;
            ptr_set_rg = (io_in == OPC_PTR_B) ? RG_SECOND :
                         (io_in == OPC_PTR_C) ? RG_SPARE : RG_FIRST;
            addr_clear = 1'b1;
            state_d    = FS_RADDR;
          end
          OPC_PGM: begin
            addr_clear = 1'b1;
            state_d    = FS_PADDR;
          end
          OPC_ERS: begin
            addr_clear = 1'b1;
            state_d    = FS_EADDR;
          end
          OPC_CPY_DST: begin
            if (src_q) begin
              addr_clear = 1'b1;
              state_d    = FS_CADDR;
            end else begin
              evt_reject = 1'b1;
              state_d    = FS_IDLE;
            end
          end
          OPC_IDENT: begin
            evt_issue = 1'b1;
            iss_kind  = OP_IDENT;
            state_d   = FS_IDLE;
          end
          OPC_CONFIRM: begin
            state_d = FS_IDLE;
            if ((state_q == FS_PADDR || state_q == FS_CADDR) &&
                addr_cnt == CNT_W'(RD_CYC)) begin
              evt_issue = 1'b1;
              iss_kind  = (state_q == FS_PADDR) ? OP_PROG : OP_COPY;
              iss_col   = region_col(ptr_q, addr_q[BYTE_W-1:0]);
              iss_row   = addr_q[ADDR_W-1:BYTE_W];
              ptr_use   = 1'b1;
              ld_long   = 1'b1;
            end else begin
              evt_reject = 1'b1;
            end
          end
          OPC_ERS_GO: begin
            state_d = FS_IDLE;
            if (state_q == FS_EADDR && addr_cnt == CNT_W'(ER_CYC)) begin
              evt_issue = 1'b1;
              iss_kind  = OP_ERASE;
              iss_row   = ROW_W'(addr_q[ER_CYC*BYTE_W-1:0]);
              ld_long   = 1'b1;
            end else begin
              evt_reject = 1'b1;
            end
          end
          default: begin
            evt_reject = 1'b1;
            state_d    = FS_IDLE;
          end
        endcase
      end
    end else if (addr_last && state_q == FS_RADDR) begin
      evt_issue = 1'b1;
      iss_kind  = OP_READ;
      iss_col   = region_col(ptr_q, addr_nx[BYTE_W-1:0]);
      iss_row   = addr_nx[ADDR_W-1:BYTE_W];
      ptr_use   = 1'b1;
      ld_long   = 1'b1;
      src_set   = 1'b1;
      state_d   = FS_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= FS_IDLE;
      src_q      <= 1'b0;
      op_valid   <= 1'b0;
      cmd_reject <= 1'b0;
      op_kind_q  <= OP_NONE;
      op_col     <= '0;
      op_row     <= '0;
      op_region  <= '0;
    end else begin
      state_q    <= state_d;
      op_valid   <= evt_issue;
      cmd_reject <= evt_reject;
      if (src_clr)      src_q <= 1'b0;
      else if (src_set) src_q <= 1'b1;
      if (evt_issue) begin
        op_kind_q <= iss_kind;
        op_col    <= iss_col;
        op_row    <= iss_row;
        op_region <= iss_rg;
      end
    end
  end

  assign op_kind = op_kind_q;
endmodule

// File: rtl/nandfe_chk.sv
module nandfe_chk
  import nandfe_pkg::*;
#(
  parameter int RD_CYC = 4,
  localparam int CNT_W = $clog2(RD_CYC + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_stb,
  input logic             cle,
  input logic             ale,
  input logic [7:0]       io_in,
  input logic             op_valid,
  input logic [2:0]       op_kind,
  input logic [COL_W-1:0] op_col,
  input logic [1:0]       op_region,
  input logic             cmd_reject,
  input logic             busy,
  input logic [1:0]       ptr_now,
  input logic [CNT_W-1:0] addr_cnt,
  input logic             evt_issue
);
  logic opc_w;
  assign opc_w = wr_stb && cle && !ale;

  assert_no_double_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && cmd_reject));

  assert_reset_any_time_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (opc_w && io_in == 8'hFF) |=> (busy && op_valid && op_kind == 3'd7 && ptr_now == 2'd0));

  assert_busy_mutes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && opc_w && io_in != 8'hFF && io_in != 8'h70) |=> (!op_valid && !cmd_reject));

  assert_array_op_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind inside {3'd1, 3'd2, 3'd3, 3'd4}) |-> busy);

  assert_second_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_region == 2'd1 && op_kind inside {3'd1, 3'd2, 3'd4}) |-> ptr_now == 2'd0);

  assert_spare_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_region == 2'd2 && op_kind inside {3'd1, 3'd2, 3'd4}) |-> ptr_now == 2'd2);

  assert_addr_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_cnt <= CNT_W'(RD_CYC));

  assert_col_in_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 3'd1) |-> op_col < COL_W'(PAGE_SIZE));

  assert_unknown_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (opc_w && !busy && !opcode_known(io_in)) |=> cmd_reject);

  assert_issue_reported_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_issue |=> op_valid);
endmodule

bind nandfe_cmd_front nandfe_chk #(.RD_CYC(RD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cle(cle), .ale(ale),
  .io_in(io_in), .op_valid(op_valid), .op_kind(op_kind), .op_col(op_col),
  .op_region(op_region), .cmd_reject(cmd_reject), .busy(busy),
  .ptr_now(ptr_q), .addr_cnt(addr_cnt), .evt_issue(evt_issue)
);

// File: tb/sim_nandfe_cmd_front.sv
module sim_nandfe_cmd_front;
  localparam int CLK_NS  = 10;
  localparam int BUSY_N  = 20;
  localparam int RESET_N = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic        cle = 1'b0;
  logic        ale = 1'b0;
  logic [7:0]  io = 8'h00;
  logic        op_valid, cmd_reject, busy;
  logic [2:0]  op_kind;
  logic [9:0]  op_col;
  logic [23:0] op_row;
  logic [1:0]  op_region;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic        rej;
    logic [2:0]  kind;
    logic [9:0]  col;
    logic [23:0] row;
    logic [1:0]  rg;
    string       tag;
  } exp_t;
  exp_t exq[$];

  always #(CLK_NS/2) clk = ~clk;

  nandfe_cmd_front #(.BUSY_CYC(BUSY_N), .RST_CYC(RESET_N)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cle(cle), .ale(ale),
    .io_in(io), .op_valid(op_valid), .op_kind(op_kind), .op_col(op_col),
    .op_row(op_row), .op_region(op_region), .cmd_reject(cmd_reject),
    .busy(busy)
  );

  // independent restatement of the column rule
  function automatic logic [9:0] want_col(input int rg, input int b);
    if (rg == 1) return 10'(256 + b);
    if (rg == 2) return 10'(512 + (b % 16));
    return 10'(b);
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic put_op(input int k, input int c, input int r, input int g, input string tag);
    exp_t e;
    e.rej = 1'b0; e.kind = 3'(k); e.col = 10'(c); e.row = 24'(r); e.rg = 2'(g); e.tag = tag;
    exq.push_back(e);
  endtask

  task automatic put_rej(input string tag);
    exp_t e;
    e.rej = 1'b1; e.kind = 3'd0; e.col = '0; e.row = '0; e.rg = '0; e.tag = tag;
    exq.push_back(e);
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] v);
    wr_stb = 1'b1; cle = c; ale = a; io = v;
    @(negedge clk);
    wr_stb = 1'b0; cle = 1'b0; ale = 1'b0;
    @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] v); wr(1'b1, 1'b0, v); endtask
  task automatic adr(input logic [7:0] v); wr(1'b0, 1'b1, v); endtask
  task automatic dat(input logic [7:0] v); wr(1'b0, 1'b0, v); endtask

  task automatic wait_ready();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // called where wr returns after the strobe that loads the counter:
  // one busy clock has already passed, so n-1 remain visible
  task automatic busy_len(input int expn, input string tag);
    int n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    check(n == expn, tag, n, expn);
  endtask

  // monitor: pops the scoreboard on every reported result
  always @(negedge clk) begin
    if (rst_n && (op_valid || cmd_reject)) begin
      if (exq.size() == 0) begin
        total++; bad++;
        $display("FAIL R10/R11 unexpected result actual kind=%0d rej=%0d expected none",
                 op_kind, cmd_reject);
      end else begin
        exp_t e;
        e = exq.pop_front();
        if (e.rej) begin
          check(cmd_reject && !op_valid, {e.tag, " reject"}, {op_valid, cmd_reject}, 1);
        end else begin
          check(op_valid && op_kind == e.kind, {e.tag, " kind"}, op_kind, e.kind);
          if (e.kind inside {3'd1, 3'd2, 3'd3, 3'd4}) begin
            check(op_col == e.col, {e.tag, " col"}, op_col, e.col);
            check(op_row == e.row, {e.tag, " row"}, op_row, e.row);
            check(op_region == e.rg, {e.tag, " region"}, op_region, e.rg);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_NS * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !op_valid && !cmd_reject, "R1 reset state", {busy, op_valid, cmd_reject}, 0);

    // R1 R6: program with no region opcode, data ignored
    cmd(8'h80); adr(8'h12); adr(8'h34); adr(8'h56); adr(8'h78); dat(8'hAA); dat(8'hBB);
    put_op(2, want_col(0, 'h12), 'h785634, 0, "R1 R6");
    cmd(8'h10);
    busy_len(BUSY_N - 1, "R11 busy length");
    wait_ready();

    // R2 R3: first-half read
    cmd(8'h00); adr(8'h05); adr(8'h01); adr(8'h02);
    put_op(1, want_col(0, 5), 'h030201, 0, "R2");
    adr(8'h03);
    wait_ready();

    // R3 R4: second half, then pointer back to first half
    cmd(8'h01); adr(8'h10); adr(8'h0A); adr(8'h0B);
    put_op(1, want_col(1, 'h10), 'h0C0B0A, 1, "R3 R4");
    adr(8'h0C);
    wait_ready();
    cmd(8'h80); adr(8'h20); adr(8'h01); adr(8'h02); adr(8'h03);
    put_op(2, want_col(0, 'h20), 'h030201, 0, "R4 revert");
    cmd(8'h10);
    wait_ready();

    // R3 R5: spare region sticks
    cmd(8'h50); adr(8'h2A); adr(8'h04); adr(8'h05);
    put_op(1, want_col(2, 'h2A), 'h060504, 2, "R3 R5");
    adr(8'h06);
    wait_ready();
    cmd(8'h80); adr(8'h03); adr(8'h07); adr(8'h08); adr(8'h09);
    put_op(2, want_col(2, 3), 'h090807, 2, "R5 sticky");
    cmd(8'h10);
    wait_ready();

    // R6 R4: program in second half with an extra address byte
    cmd(8'h00); cmd(8'h01); cmd(8'h80);
    adr(8'hFF); adr(8'h01); adr(8'h02); adr(8'h03); adr(8'h04); dat(8'h5A);
    put_op(2, want_col(1, 'hFF), 'h030201, 1, "R6 extra addr");
    cmd(8'h10);
    wait_ready();

    // R7: erase with an extra address byte
    cmd(8'h60); adr(8'h11); adr(8'h22); adr(8'h33); adr(8'h44);
    put_op(3, 0, 'h332211, 0, "R7");
    cmd(8'hD0);
    busy_len(BUSY_N - 1, "R11 erase busy");
    wait_ready();

    // R8: copy-back after a read
    cmd(8'h00); adr(8'h40); adr(8'h01); adr(8'h02);
    put_op(1, want_col(0, 'h40), 'h030201, 0, "R8 source");
    adr(8'h03);
    wait_ready();
    cmd(8'h8A); adr(8'h41); adr(8'h04); adr(8'h05); adr(8'h06);
    put_op(4, want_col(0, 'h41), 'h060504, 0, "R8");
    cmd(8'h10);
    wait_ready();

    // R12: reset homes pointer and drops the copy source
    cmd(8'h50);
    put_op(7, 0, 0, 0, "R12");
    cmd(8'hFF);
    busy_len(RESET_N - 1, "R12 reset busy");
    wait_ready();
    put_rej("R8 R12 no source");
    cmd(8'h8A);
    cmd(8'h80); adr(8'h07); adr(8'h01); adr(8'h01); adr(8'h01);
    put_op(2, want_col(0, 7), 'h010101, 0, "R12 pointer home");
    cmd(8'h10);
    wait_ready();

    // R9: confirms without a full sequence
    put_rej("R9 lone confirm");
    cmd(8'h10);
    cmd(8'h60); adr(8'h01); adr(8'h02);
    put_rej("R9 short erase");
    cmd(8'hD0);
    cmd(8'h80); adr(8'h01); adr(8'h02); adr(8'h03);
    put_rej("R9 short program");
    cmd(8'h10);

    // R10: undefined opcode, then stray address bytes do nothing
    cmd(8'h00); adr(8'h09); adr(8'h09);
    put_rej("R10");
    cmd(8'h33);
    adr(8'h09); adr(8'h09); adr(8'h09);
    repeat (6) @(negedge clk);
    check(exq.size() == 0, "R10 idle after reject", exq.size(), 0);

    // R11 R13: busy mutes all but status
    cmd(8'h00); adr(8'h01); adr(8'h02); adr(8'h03);
    put_op(1, want_col(0, 1), 'h040302, 0, "R11 read");
    adr(8'h04);
    cmd(8'h80); cmd(8'h01); cmd(8'h60); cmd(8'h90); cmd(8'h33); adr(8'h05);
    put_op(5, 0, 0, 0, "R13 status busy");
    cmd(8'h70);
    check(busy == 1'b1, "R11 still busy", busy, 1);
    wait_ready();
    cmd(8'h80); adr(8'h31); adr(8'h07); adr(8'h08); adr(8'h09);
    put_op(2, want_col(0, 'h31), 'h090807, 0, "R11 pointer untouched");
    cmd(8'h10);
    wait_ready();
    put_op(6, 0, 0, 0, "R13 ident");
    cmd(8'h90);
    put_op(5, 0, 0, 0, "R13 status ready");
    cmd(8'h70);

    // R12: reset while busy
    cmd(8'h00); adr(8'h02); adr(8'h01); adr(8'h01);
    put_op(1, want_col(0, 2), 'h010101, 0, "R12 pre read");
    adr(8'h01);
    put_op(7, 0, 0, 0, "R12 during busy");
    cmd(8'hFF);
    busy_len(RESET_N - 1, "R12 reload");
    wait_ready();

    repeat (5) @(negedge clk);
    check(exq.size() == 0, "R2 all results seen", exq.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule